// File: doc/BRIEF.md
# Key-Protected System Enable Register

This block is a single 16-bit control word on a simple peripheral bus. It holds two chip-level enables: one that lets the on-chip read-only memory be used, and one that switches on the external bus. Both are driven straight out of the register flops to the rest of the chip.

Software cannot change the word by accident. A write counts only if it is a full 16-bit access (both byte lanes enabled) and its high byte carries the fixed unlock code 0x5A. The code itself is never stored. The memory enable is one-way: once it is cleared, it stays cleared until the next reset. The external bus enable can be set and cleared as often as software likes. A write that hits the register address but fails either test changes nothing and raises a one-cycle reject pulse.

Top module: `scr_keyed_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the register reads 0x0001 at its address, `rom_en` is 1, `extbus_en` is 0 and `key_error` is 0.
- R2: A write is accepted when `bus_we` is 1, `bus_addr` equals `REG_ADDR` (default 0x03), `bus_be` is 2'b11 and `bus_wdata[15:8]` is 0x5A. Bit 0 of the write data is the memory enable and bit 1 is the external bus enable.
- R3: A write to `REG_ADDR` whose high byte is not 0x5A leaves both enables unchanged.
- R4: A write to `REG_ADDR` with `bus_be` other than 2'b11 leaves both enables unchanged, even when the enabled byte holds 0x5A.
- R5: Read data bits 15..2 are always 0, whatever was written to them.
- R6: After `rom_en` reaches 0, it stays 0 until reset, even when accepted writes carry 1 in bit 0.
- R7: Accepted writes copy bit 1 of the write data into `extbus_en`, in both directions, and the new value reads back on the next cycle.
- R8: A write to any other address changes nothing and raises no `key_error`. A read of any other address returns 0.
- R9: `rom_en`, `extbus_en` and read bits 1..0 change on the same clock edge that accepts the write.
- R10: `key_error` is 1 for exactly the cycle after each rejected write to `REG_ADDR`, and 0 otherwise. Back-to-back rejections keep it high for one cycle per rejection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 16 | Write data, high byte carries the unlock code |
| bus_be | input | 2 | Byte-lane enables, bit 1 = high byte |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 16 | Combinational read of the register when the address matches, else 0 |
| rom_en | output | 1 | Memory enable |
| extbus_en | output | 1 | External bus enable |
| key_error | output | 1 | Pulse after a rejected write to the register |

## Verification
Two things can fall in the same cycle: a rejected write that carries a 1 in bit 0 after the memory enable has already been cleared, and the reject pulse left over from the previous rejected write. The bench provokes this by issuing wrong-key and partial-lane writes back to back, both before and after the one-way clear. A per-cycle reference model then judges that the enables stay put, that the sticky bit never comes back, and that `key_error` stays high for exactly as many cycles as there were rejections.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int REG_W    = 16;
  localparam int LANE_W   = 8;
  localparam int LANES    = REG_W / LANE_W;
  localparam int CODE_LSB = REG_W - LANE_W;
  localparam int ROM_BIT  = 0;
  localparam int EXT_BIT  = 1;

  typedef struct packed {
    logic ext;
    logic rom;
  } scr_fields_t;

  // Full-width access: every byte lane enabled.
  function automatic logic lanes_full(input logic [LANES-1:0] be);
    return &be;
  endfunction

  function automatic logic code_ok(input logic [LANE_W-1:0] code_byte,
                                   input logic [LANE_W-1:0] unlock);
    return code_byte == unlock;
  endfunction

  // Memory enable may only fall; external bus enable follows the data.
  function automatic scr_fields_t merge_fields(input scr_fields_t cur,
                                               input logic [1:0] low_bits);
    scr_fields_t nxt;
    nxt.rom = cur.rom & low_bits[ROM_BIT];
    nxt.ext = low_bits[EXT_BIT];
    return nxt;
  endfunction

  function automatic logic [REG_W-1:0] read_image(input scr_fields_t f);
    logic [REG_W-1:0] img;
    img          = '0;
    img[ROM_BIT] = f.rom;
    img[EXT_BIT] = f.ext;
    return img;
  endfunction
endpackage

// File: rtl/scr_access_decode.sv
module scr_access_decode
  import scr_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h03,
  parameter logic [LANE_W-1:0] UNLOCK   = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] code_byte,
  input  logic [LANES-1:0]  be,
  input  logic              we,
  output logic              addr_hit,
  output logic              write_accept,
  output logic              write_reject
);
  logic qualified;

  always_comb begin
    addr_hit     = (addr == REG_ADDR);
    qualified    = lanes_full(be) && code_ok(code_byte, UNLOCK);
    write_accept = we && addr_hit && qualified;
    write_reject = we && addr_hit && !qualified;
  end
endmodule

// File: rtl/scr_field_store.sv
module scr_field_store
  import scr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        write_accept,
  input  logic [1:0]  low_bits,
  output scr_fields_t fields
);
  localparam scr_fields_t RESET_FIELDS = '{ext: 1'b0, rom: 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= RESET_FIELDS;
    end else if (write_accept) begin
      fields <= merge_fields(fields, low_bits);
    end
  end
endmodule

// File: rtl/scr_reject_pulse.sv
module scr_reject_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic write_reject,
  output logic key_error
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_error <= 1'b0;
    end else begin
      key_error <= write_reject;
    end
  end
endmodule

// File: rtl/scr_keyed_ctrl.sv
module scr_keyed_ctrl
  import scr_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h03,
  parameter logic [LANE_W-1:0] UNLOCK   = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [LANES-1:0]  bus_be,
  input  logic              bus_we,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rom_en,
  output logic              extbus_en,
  output logic              key_error
);
  logic        addr_hit;
  logic        write_accept;
  logic        write_reject;
  scr_fields_t fields;
  logic        unused_wdata_bits;

  // Reserved data bits are discarded by design.
  assign unused_wdata_bits = &{1'b0, bus_wdata[CODE_LSB-1:2]};

  scr_access_decode #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .UNLOCK  (UNLOCK)
  ) u_decode (
    .addr        (bus_addr),
    .code_byte   (bus_wdata[REG_W-1:CODE_LSB]),
    .be          (bus_be),
    .we          (bus_we),
    .addr_hit    (addr_hit),
    .write_accept(write_accept),
    .write_reject(write_reject)
  );

  scr_field_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .write_accept(write_accept),
    .low_bits    (bus_wdata[1:0]),
    .fields      (fields)
  );

  scr_reject_pulse u_reject (
    .clk         (clk),
    .rst_n       (rst_n),
    .write_reject(write_reject),
    .key_error   (key_error)
  );

  assign rom_en    = fields.rom;
  assign extbus_en = fields.ext;
  assign bus_rdata = addr_hit ? read_image(fields) : '0;
endmodule

// File: rtl/scr_keyed_ctrl_chk.sv
module scr_keyed_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              rom_en,
  input logic              extbus_en,
  input logic              key_error,
  input logic              addr_hit,
  input logic              write_accept,
  input logic              write_reject
);
  always_comb begin
    if (rst_n) begin
      assert_rdata_high_zero_R5: assert (bus_rdata[15:2] == 14'h0);
    end
  end

  assert_rom_one_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en |=> !rom_en);

  assert_reject_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    write_reject |=> ($stable(rom_en) && $stable(extbus_en)));

  assert_reject_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    write_reject |=> key_error);

  assert_no_spurious_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !write_reject |=> !key_error);

  assert_miss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !addr_hit) |=> ($stable(rom_en) && $stable(extbus_en) && !key_error));

  assert_ext_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    write_accept |=> (extbus_en == $past(bus_wdata[1])));

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> (bus_rdata[1:0] == {extbus_en, rom_en}));
endmodule

bind scr_keyed_ctrl scr_keyed_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .rom_en      (rom_en),
  .extbus_en   (extbus_en),
  .key_error   (key_error),
  .addr_hit    (addr_hit),
  .write_accept(write_accept),
  .write_reject(write_reject)
);

// File: tb/tb_scr_keyed_ctrl.sv
`timescale 1ns/1ps
module tb_scr_keyed_ctrl;
  localparam int ADDR_W = 8;
  localparam logic [7:0] REG_A = 8'h03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = REG_A;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_be = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic        rom_en, extbus_en, key_error;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference state.
  bit m_rom = 1, m_ext = 0, m_err = 0;

  always #10 clk = ~clk;

  scr_keyed_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .rom_en(rom_en), .extbus_en(extbus_en), .key_error(key_error));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rom <= 1; m_ext <= 0; m_err <= 0;
    end else if (bus_we && bus_addr == REG_A) begin
      if (bus_be == 2'b11 && bus_wdata[15:8] == 8'h5A) begin
        if (bus_wdata[0] == 0) m_rom <= 0;
        m_ext <= bus_wdata[1];
        m_err <= 0;
      end else begin
        m_err <= 1;
      end
    end else begin
      m_err <= 0;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int exp_rd;
    exp_rd = (bus_addr == REG_A) ? (m_ext * 2 + m_rom) : 0;
    chk("rdata", bus_rdata, exp_rd);
    chk("rom_en", rom_en, m_rom);
    chk("extbus_en", extbus_en, m_ext);
    chk("key_error", key_error, m_err);
  endtask

  // Check the state left by the previous cycle, then drive the next one.
  task automatic step(input string req, input logic [7:0] a, input logic [15:0] wd,
                      input logic [1:0] be, input logic we);
    @(negedge clk);
    compare();
    cur_req = req;
    bus_addr = a; bus_wdata = wd; bus_be = be; bus_we = we;
  endtask

  task automatic idle(input string req);
    step(req, REG_A, 16'h0, 2'b00, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();                              // R1 during reset
    rst_n = 1'b1;
    idle("R1"); idle("R1");
    // R7: external enable set, cleared, set again
    step("R7", REG_A, 16'h5A03, 2'b11, 1);
    step("R9", REG_A, 16'h5A01, 2'b11, 1);
    step("R7", REG_A, 16'h5A03, 2'b11, 1);
    idle("R7");
    // R5: reserved and code bits never read back
    step("R5", REG_A, 16'h5AFD, 2'b11, 1);
    idle("R5");
    // R3: wrong codes, back to back, then one alone
    step("R3", REG_A, 16'h0000, 2'b11, 1);
    step("R10", REG_A, 16'hA501, 2'b11, 1);
    step("R10", REG_A, 16'h5B03, 2'b11, 1);
    idle("R10"); idle("R3");
    // R4: partial lanes, even with the code in the high byte
    step("R4", REG_A, 16'h5A01, 2'b10, 1);
    step("R4", REG_A, 16'h5A5A, 2'b01, 1);
    step("R4", REG_A, 16'h5A01, 2'b00, 1);
    idle("R4"); idle("R4");
    // R8: other addresses
    step("R8", 8'h02, 16'h5A00, 2'b11, 1);
    step("R8", 8'h04, 16'h0000, 2'b11, 1);
    step("R8", 8'h83, 16'h5A00, 2'b11, 0);
    idle("R8");
    // R6/R2: one-way clear of the memory enable
    step("R2", REG_A, 16'h5A02, 2'b11, 1);
    step("R6", REG_A, 16'h5A03, 2'b11, 1);
    step("R6", REG_A, 16'h5A01, 2'b11, 1);
    // rejection with bit 0 set after the clear, coinciding with a pulse
    step("R10", REG_A, 16'h1201, 2'b11, 1);
    step("R6", REG_A, 16'h5A01, 2'b01, 1);
    step("R7", REG_A, 16'h5A00, 2'b11, 1);
    idle("R6"); idle("R6");
    // R1: reset restores the memory enable
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    cur_req = "R1";
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle("R1"); idle("R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule